// File: doc/BRIEF.md
# Banked CPU Register File

This block holds the working registers of an 8-bit processor core. Thirty-two byte registers are arranged as four banks of eight. Two bank-select bits in the program status word pick the bank that is active, and they do so live: software switches context by writing the status word. Next to the banks sit a 16-bit stack pointer, the status word itself, two segment registers (code and extra) and one processor-mode control byte.

A single selector addresses every register through one read port and one write port. A byte selector reaches one register of the active bank. A pair selector joins a fixed high and low byte into a 16-bit word. Reads are combinational. Writes land on the rising clock edge. A branch-condition evaluator reads the carry and zero flags of the status word, or tests a value the core supplies, and returns a single taken bit.

Decode mistakes are visible to the core. A selector that names no register, or a write to the "none" selector, raises an error and changes nothing. A stack-pointer write with an odd value is made even, and a pulse reports each such correction.

Top module: `banked_regfile`

## Requirements
- R1: After a synchronous reset, every byte register in all four banks reads 0x11. The status word reads 0x06, the stack pointer 0x0000, the extra segment 0x0F, the code segment 0x00 and the mode byte 0x00.
- R2: Byte selectors 0x08..0x0F address the active bank's registers X, A, C, B, E, D, L and H in that order. A read returns the byte zero-extended to 16 bits, and a write stores wr_data[7:0] on the rising edge.
- R3: The active bank number is status bit 5 times two plus status bit 3. A status-word write changes the bank seen from the cycle after that edge. Each bank keeps its own contents.
- R4: Pair selectors 0x10, 0x11, 0x12 and 0x13 are AX, BC, DE and HL, with A, B, D and H as the high bytes. A pair read returns high*256+low. A pair write puts wr_data[15:8] in the high byte and wr_data[7:0] in the low byte.
- R5: Selector 0x18 is the stack pointer. A write stores wr_data with bit 0 cleared, and sp_fixup is high during any stack-pointer write whose bit 0 is 1.
- R6: Selectors 0x19 (status word), 0x1A (code segment), 0x1B (extra segment) and 0x1C (mode byte) are 8-bit registers. They read zero-extended and store wr_data[7:0].
- R7: Condition codes 2..7 are C, NC, H, NH, Z and NZ. C is true when carry (status bit 0) is set, and NC is its inverse. Z is true when zero (status bit 6) is set, and NZ is its inverse. H is true when both flags are clear, and NH is true when either flag is set.
- R8: Condition code 0 (T) is true when cond_val is nonzero. Condition code 1 (F) is true when cond_val is zero.
- R9: A read of an undefined selector (any value not listed in R2, R4, R5 and R6, other than 0x00) returns 0 and raises sel_err. A read of selector 0x00 returns 0 without error.
- R10: A write to selector 0x00 or to an undefined selector raises sel_err in that cycle and leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_sel | input | 5 | Read register selector |
| rd_data | output | 16 | Combinational read data |
| wr_en | input | 1 | Write enable |
| wr_sel | input | 5 | Write register selector |
| wr_data | input | 16 | Write data |
| cond_sel | input | 3 | Branch condition code |
| cond_val | input | 16 | Value tested by conditions T and F |
| cond_true | output | 1 | Condition result |
| sp_fixup | output | 1 | Odd stack-pointer write was made even |
| sel_err | output | 1 | Undefined read selector or illegal write selector |

## Verification
The bench writes a marker into one bank and then walks through the other three. A design with the bank bits swapped, or one that ignores a select bit, would show the marker in the wrong bank. Pair writes and reads check byte placement, since swapped halves would turn 0xBEEF into 0xEFBE. An odd stack-pointer write must read back even and pulse the flag, while an even write must not pulse. Writes to the "none" selector and to an undefined selector are followed by read-back of the status word, the stack pointer and a pair, to catch a decoder that lets an illegal write through. The condition tests cover all four carry/zero combinations, where an H built as OR instead of NOR would disagree.

// File: rtl/regfile_pkg.sv
package regfile_pkg;

    localparam int BANK_W = 2;
    localparam int OFF_W  = 3;
    localparam int SEL_W  = 5;

    // status word bit positions
    localparam int PSW_CY  = 0;
    localparam int PSW_RB0 = 3;
    localparam int PSW_RB1 = 5;
    localparam int PSW_Z   = 6;

    typedef enum logic [3:0] {
        K_NONE, K_BYTE, K_PAIR, K_SP, K_PSW, K_CS, K_ES, K_PMC, K_BAD
    } sel_kind_e;

    typedef struct packed {
        sel_kind_e         kind;
        logic [OFF_W-1:0]  idx;
    } sel_t;

    typedef enum logic [2:0] {
        CC_T, CC_F, CC_C, CC_NC, CC_H, CC_NH, CC_Z, CC_NZ
    } cond_e;

    function automatic sel_t decode_sel(input logic [SEL_W-1:0] s);
        sel_t r;
        r.idx  = s[OFF_W-1:0];
        r.kind = K_BAD;
        if (s == 5'h00)                  r.kind = K_NONE;
        else if (s[4:3] == 2'b01)        r.kind = K_BYTE;
        else if (s[4:2] == 3'b100)       r.kind = K_PAIR;
        else if (s == 5'h18)             r.kind = K_SP;
        else if (s == 5'h19)             r.kind = K_PSW;
        else if (s == 5'h1A)             r.kind = K_CS;
        else if (s == 5'h1B)             r.kind = K_ES;
        else if (s == 5'h1C)             r.kind = K_PMC;
        return r;
    endfunction

endpackage

// File: rtl/rf_bank_store.sv
module rf_bank_store #(
    parameter int        BANKS   = 4,
    parameter int        REGS    = 8,
    parameter logic [7:0] RST_VAL = 8'h11,
    localparam int       SLOTS   = BANKS * REGS,
    localparam int       AW      = $clog2(SLOTS),
    localparam int       BW      = $clog2(BANKS),
    localparam int       OW      = $clog2(REGS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [BW-1:0] bank,
    input  logic [OW-1:0] rd_off_lo,
    input  logic [OW-1:0] rd_off_hi,
    output logic [7:0]    rd_lo,
    output logic [7:0]    rd_hi,
    input  logic          we_lo,
    input  logic [OW-1:0] wr_off_lo,
    input  logic [7:0]    wd_lo,
    input  logic          we_hi,
    input  logic [OW-1:0] wr_off_hi,
    input  logic [7:0]    wd_hi
);
    logic [7:0] mem [SLOTS];

    // banks are laid out in reverse: bank n lives in slot group (BANKS-1-n)
    function automatic logic [AW-1:0] slot_of(input logic [BW-1:0] b, input logic [OW-1:0] o);
        return AW'((BANKS - 1 - int'(b)) * REGS + int'(o));
    endfunction

    logic [AW-1:0] ws_lo, ws_hi;
    assign ws_lo = slot_of(bank, wr_off_lo);
    assign ws_hi = slot_of(bank, wr_off_hi);
    assign rd_lo = mem[slot_of(bank, rd_off_lo)];
    assign rd_hi = mem[slot_of(bank, rd_off_hi)];

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                mem[i] <= RST_VAL;
            else if (we_lo && ws_lo == AW'(i))
                mem[i] <= wd_lo;
            else if (we_hi && ws_hi == AW'(i))
                mem[i] <= wd_hi;
        end
    end
endmodule

// File: rtl/rf_cond_eval.sv
module rf_cond_eval
    import regfile_pkg::*;
(
    input  logic [7:0]  psw,
    input  logic [2:0]  cond_sel,
    input  logic [15:0] cond_val,
    output logic        cond_true
);
    logic z, cy;
    assign z  = psw[PSW_Z];
    assign cy = psw[PSW_CY];

    always_comb begin
        unique case (cond_e'(cond_sel))
            CC_T:    cond_true = (cond_val != 16'h0);
            CC_F:    cond_true = (cond_val == 16'h0);
            CC_C:    cond_true = cy;
            CC_NC:   cond_true = !cy;
            CC_H:    cond_true = !(z | cy);
            CC_NH:   cond_true = z | cy;
            CC_Z:    cond_true = z;
            default: cond_true = !z;
        endcase
    end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import regfile_pkg::*;
#(
    parameter logic [7:0]  RST_BYTE = 8'h11,
    parameter logic [7:0]  RST_PSW  = 8'h06,
    parameter logic [7:0]  RST_ES   = 8'h0F,
    parameter logic [7:0]  RST_CS   = 8'h00,
    parameter logic [7:0]  RST_PMC  = 8'h00,
    parameter logic [15:0] RST_SP   = 16'h0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [4:0]  rd_sel,
    output logic [15:0] rd_data,
    input  logic        wr_en,
    input  logic [4:0]  wr_sel,
    input  logic [15:0] wr_data,
    input  logic [2:0]  cond_sel,
    input  logic [15:0] cond_val,
    output logic        cond_true,
    output logic        sp_fixup,
    output logic        sel_err
);
    localparam int NBANK = 1 << BANK_W;
    localparam int NREG  = 1 << OFF_W;

    logic [7:0]  psw_q, cs_q, es_q, pmc_q;
    logic [15:0] sp_q;
    sel_t        rs, ws;
    logic [BANK_W-1:0] bank;
    logic [OFF_W-1:0]  rd_off_lo, rd_off_hi, wr_off_lo, wr_off_hi;
    logic [7:0]  rd_lo, rd_hi;
    logic        we_lo, we_hi, wr_ok;

    assign rs   = decode_sel(rd_sel);
    assign ws   = decode_sel(wr_sel);
    assign bank = {psw_q[PSW_RB1], psw_q[PSW_RB0]};

    // pair p: low byte at offset 2p, high byte at 2p+1
    assign rd_off_lo = (rs.kind == K_PAIR) ? {rs.idx[1:0], 1'b0} : rs.idx;
    assign rd_off_hi = {rs.idx[1:0], 1'b1};
    assign wr_off_lo = (ws.kind == K_PAIR) ? {ws.idx[1:0], 1'b0} : ws.idx;
    assign wr_off_hi = {ws.idx[1:0], 1'b1};

    assign wr_ok = wr_en && (ws.kind != K_NONE) && (ws.kind != K_BAD);
    assign we_lo = wr_ok && (ws.kind == K_BYTE || ws.kind == K_PAIR);
    assign we_hi = wr_ok && (ws.kind == K_PAIR);

    rf_bank_store #(.BANKS(NBANK), .REGS(NREG), .RST_VAL(RST_BYTE)) i_store (
        .clk(clk), .rst(rst), .bank(bank),
        .rd_off_lo(rd_off_lo), .rd_off_hi(rd_off_hi),
        .rd_lo(rd_lo), .rd_hi(rd_hi),
        .we_lo(we_lo), .wr_off_lo(wr_off_lo), .wd_lo(wr_data[7:0]),
        .we_hi(we_hi), .wr_off_hi(wr_off_hi), .wd_hi(wr_data[15:8])
    );

    rf_cond_eval i_cond (
        .psw(psw_q), .cond_sel(cond_sel), .cond_val(cond_val), .cond_true(cond_true)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            psw_q <= RST_PSW;
            cs_q  <= RST_CS;
            es_q  <= RST_ES;
            pmc_q <= RST_PMC;
            sp_q  <= RST_SP;
        end else if (wr_ok) begin
            unique case (ws.kind)
                K_SP:    sp_q  <= {wr_data[15:1], 1'b0};
                K_PSW:   psw_q <= wr_data[7:0];
                K_CS:    cs_q  <= wr_data[7:0];
                K_ES:    es_q  <= wr_data[7:0];
                K_PMC:   pmc_q <= wr_data[7:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (rs.kind)
            K_BYTE:  rd_data = {8'h00, rd_lo};
            K_PAIR:  rd_data = {rd_hi, rd_lo};
            K_SP:    rd_data = sp_q;
            K_PSW:   rd_data = {8'h00, psw_q};
            K_CS:    rd_data = {8'h00, cs_q};
            K_ES:    rd_data = {8'h00, es_q};
            K_PMC:   rd_data = {8'h00, pmc_q};
            default: rd_data = 16'h0000;
        endcase
    end

    assign sp_fixup = wr_ok && (ws.kind == K_SP) && wr_data[0];
    assign sel_err  = (rs.kind == K_BAD) ||
                      (wr_en && (ws.kind == K_NONE || ws.kind == K_BAD));

    // R5
    sp_even_chk: assert property (@(posedge clk) disable iff (rst) !sp_q[0]);

    // R5
    sp_fixup_store_chk: assert property (@(posedge clk) disable iff (rst)
        sp_fixup |=> (sp_q == ($past(wr_data) & 16'hFFFE)));

    // R3
    bank_switch_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 5'h19) |=> (bank == {$past(wr_data[PSW_RB1]), $past(wr_data[PSW_RB0])}));

    // R10
    bad_write_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel_err && (rs.kind != K_BAD)) |=>
        ($stable(psw_q) && $stable(sp_q) && $stable(cs_q) && $stable(es_q) && $stable(pmc_q)));

    // R9
    bad_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rs.kind == K_BAD) |-> (rd_data == 16'h0000 && sel_err));
endmodule

// File: tb/test_banked_regfile.sv
module test_banked_regfile;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  rd_sel = '0;
    logic [15:0] rd_data;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  cond_sel = '0;
    logic [15:0] cond_val = '0;
    logic        cond_true, sp_fixup, sel_err;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    banked_regfile i_banked_regfile (
        .clk(clk), .rst(rst), .rd_sel(rd_sel), .rd_data(rd_data),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .cond_sel(cond_sel), .cond_val(cond_val), .cond_true(cond_true),
        .sp_fixup(sp_fixup), .sel_err(sel_err)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [4:0] s, input string req, input logic [15:0] exp);
        @(negedge clk);
        rd_sel = s;
        #1 check(req, rd_data, exp);
    endtask

    task automatic wr(input logic [4:0] s, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cond(input logic [2:0] c, input logic [15:0] v, input string req, input logic exp);
        @(negedge clk);
        cond_sel = c; cond_val = v;
        #1 check(req, {15'h0, cond_true}, {15'h0, exp});
    endtask

    task automatic t_reset;
        for (int s = 8; s < 20; s++) rd(5'(s), "R1 reg", (s < 16) ? 16'h0011 : 16'h1111);
        rd(5'h19, "R1 psw", 16'h0006);
        rd(5'h18, "R1 sp",  16'h0000);
        rd(5'h1B, "R1 es",  16'h000F);
        rd(5'h1A, "R1 cs",  16'h0000);
        rd(5'h1C, "R1 pmc", 16'h0000);
    endtask

    task automatic t_bytes_banks;
        wr(5'h0A, 16'hFF77);            // C in bank 0
        rd(5'h0A, "R2 byte write", 16'h0077);
        rd(5'h11, "R2 C in BC low", 16'h1177);
        wr(5'h19, 16'h0028);            // bank 3
        rd(5'h0A, "R3 bank3 fresh", 16'h0011);
        wr(5'h09, 16'h005A);
        rd(5'h09, "R3 bank3 A", 16'h005A);
        wr(5'h19, 16'h0020);            // bank 2
        rd(5'h09, "R3 bank2 A", 16'h0011);
        wr(5'h19, 16'h0008);            // bank 1
        rd(5'h09, "R3 bank1 A", 16'h0011);
        wr(5'h19, 16'h0000);            // bank 0
        rd(5'h0A, "R3 bank0 C kept", 16'h0077);
        rd(5'h09, "R3 bank0 A", 16'h0011);
        wr(5'h19, 16'h0028);
        rd(5'h09, "R3 bank3 A kept", 16'h005A);
        wr(5'h19, 16'h0000);
    endtask

    task automatic t_pairs;
        wr(5'h10, 16'hBEEF);
        rd(5'h09, "R4 A high", 16'h00BE);
        rd(5'h08, "R4 X low",  16'h00EF);
        rd(5'h10, "R4 AX",     16'hBEEF);
        wr(5'h0F, 16'h0012);
        wr(5'h0E, 16'h0034);
        rd(5'h13, "R4 HL", 16'h1234);
        wr(5'h12, 16'hA55A);
        rd(5'h0D, "R4 D high", 16'h00A5);
        rd(5'h0C, "R4 E low",  16'h005A);
    endtask

    task automatic t_sp;
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 5'h18; wr_data = 16'h1235;
        #1 check("R5 fixup pulse odd", {15'h0, sp_fixup}, 16'h1);
        @(negedge clk);
        wr_en = 1'b0;
        #1 check("R5 fixup drops", {15'h0, sp_fixup}, 16'h0);
        rd(5'h18, "R5 sp even", 16'h1234);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 5'h18; wr_data = 16'hFFFE;
        #1 check("R5 no pulse even", {15'h0, sp_fixup}, 16'h0);
        @(negedge clk);
        wr_en = 1'b0;
        rd(5'h18, "R5 sp even write", 16'hFFFE);
    endtask

    task automatic t_special;
        wr(5'h1A, 16'hAB3C);
        rd(5'h1A, "R6 cs", 16'h003C);
        wr(5'h1B, 16'h0001);
        rd(5'h1B, "R6 es", 16'h0001);
        wr(5'h1C, 16'h00C3);
        rd(5'h1C, "R6 pmc", 16'h00C3);
    endtask

    task automatic t_cond;
        wr(5'h19, 16'h0000);    // z=0 cy=0
        cond(3'd4, 0, "R7 H clear", 1'b1);
        cond(3'd5, 0, "R7 NH clear", 1'b0);
        cond(3'd2, 0, "R7 C clear", 1'b0);
        cond(3'd3, 0, "R7 NC clear", 1'b1);
        cond(3'd6, 0, "R7 Z clear", 1'b0);
        cond(3'd7, 0, "R7 NZ clear", 1'b1);
        wr(5'h19, 16'h0001);    // cy only
        cond(3'd4, 0, "R7 H cy", 1'b0);
        cond(3'd5, 0, "R7 NH cy", 1'b1);
        cond(3'd2, 0, "R7 C cy", 1'b1);
        wr(5'h19, 16'h0040);    // z only
        cond(3'd4, 0, "R7 H z", 1'b0);
        cond(3'd6, 0, "R7 Z z", 1'b1);
        cond(3'd3, 0, "R7 NC z", 1'b1);
        wr(5'h19, 16'h0041);
        cond(3'd5, 0, "R7 NH both", 1'b1);
        cond(3'd7, 0, "R7 NZ both", 1'b0);
        cond(3'd0, 16'h0100, "R8 T nonzero", 1'b1);
        cond(3'd0, 16'h0000, "R8 T zero", 1'b0);
        cond(3'd1, 16'h0000, "R8 F zero", 1'b1);
        cond(3'd1, 16'h8000, "R8 F nonzero", 1'b0);
        wr(5'h19, 16'h0000);
    endtask

    task automatic t_errors;
        @(negedge clk);
        rd_sel = 5'h1F;
        #1 check("R9 bad read data", rd_data, 16'h0000);
        check("R9 bad read err", {15'h0, sel_err}, 16'h1);
        rd_sel = 5'h00;
        #1 check("R9 none read data", rd_data, 16'h0000);
        check("R9 none read no err", {15'h0, sel_err}, 16'h0);
        rd_sel = 5'h05;
        #1 check("R9 low undefined read err", {15'h0, sel_err}, 16'h1);
        rd_sel = 5'h10;
        wr_en = 1'b1; wr_sel = 5'h00; wr_data = 16'hFFFF;
        #1 check("R10 none write err", {15'h0, sel_err}, 16'h1);
        @(negedge clk);
        wr_sel = 5'h05;
        #1 check("R10 undefined write err", {15'h0, sel_err}, 16'h1);
        @(negedge clk);
        wr_sel = 5'h1E;
        #1 check("R10 high undefined write err", {15'h0, sel_err}, 16'h1);
        @(negedge clk);
        wr_en = 1'b0;
        #1 check("R10 err clears", {15'h0, sel_err}, 16'h0);
        rd(5'h10, "R10 AX kept", 16'hBEEF);
        rd(5'h19, "R10 psw kept", 16'h0000);
        rd(5'h18, "R10 sp kept", 16'hFFFE);
        rd(5'h1B, "R10 es kept", 16'h0001);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_bytes_banks;
        t_pairs;
        t_sp;
        t_special;
        t_cond;
        t_errors;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end
endmodule